// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller with Vector Output

This block joins two eight-line interrupt controller cores into one sixteen-line controller. Request line n goes to core n>>3, local line n&7. Lines 0 to 7 go to the primary core and lines 8 to 15 go to the secondary core. Whenever the secondary core holds a pending request, it marks primary line 2 as pending, in the same way as an edge arriving on that line. The external request on line 2 is therefore not connected. The primary core drives the CPU interrupt line.

When the CPU strobes acknowledge, the block picks the winning line. If that line is the cascade line, the block also acknowledges the secondary core. One cycle after the strobe it presents an 8-bit vector and the 16-line IRQ number. A spurious fallback vector is used when nothing can be delivered. Configuration comes from plain input ports: a vector base per core and a trigger-select byte per core.

Priority is fixed, with line 0 the highest. End of interrupt is automatic, so there is no in-service state. The programming register interface is outside this block.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A line in edge mode (its trigger-select bit is 0) becomes pending on a 0-to-1 transition of its request. It stays pending after the request falls, until that line is acknowledged.
- R2: A line in level mode (its trigger-select bit is 1) is pending exactly while its request is high, as sampled on the previous clock edge. Acknowledging it does not clear it while the request stays high.
- R3: Trigger-select bits are ANDed with 0xF8 on the primary core and with 0xDE on the secondary core. Primary lines 0, 1 and 2 and secondary lines 8 and 13 are therefore always edge mode.
- R4: On acknowledge, the lowest-numbered pending primary line wins. For a winner other than line 2, the vector is the primary base plus the line and the IRQ number is the line. An edge-mode winner is cleared.
- R5: Any pending secondary line makes primary line 2 pending on the same edge. The external request on line 2 has no effect.
- R6: When primary line 2 wins and the secondary core has a pending line, the lowest such line s is acknowledged. The vector is the secondary base plus s and the IRQ number is 8+s.
- R7: When primary line 2 wins and no secondary line is pending, the vector is the secondary base plus 7 and the IRQ number is 15.
- R8: When nothing is pending in the primary core at acknowledge, the vector is the primary base plus 7 and the IRQ number is 7.
- R9: Bits 2:0 of both vector bases are ignored and taken as zero.
- R10: `ack_done_o` pulses for exactly one cycle, on the cycle after `ack_i`. `vec_o` and `irq_num_o` are valid with it.
- R11: `int_o` is high exactly when a primary line is pending. Reset clears all pending and edge-history state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Request lines; bit n is IRQ n |
| trig_pri_i | input | 8 | Primary trigger select (1 = level) |
| trig_sec_i | input | 8 | Secondary trigger select (1 = level) |
| base_pri_i | input | 8 | Primary vector base |
| base_sec_i | input | 8 | Secondary vector base |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| int_o | output | 1 | Interrupt request to the CPU |
| ack_done_o | output | 1 | Vector valid pulse |
| vec_o | output | 8 | Acknowledged vector |
| irq_num_o | output | 4 | Acknowledged 16-line IRQ number |

## Verification
The bench targets several cascade corner cases.
- Two secondary lines pending at once. A design that fails to re-mark line 2 after the first acknowledge loses the second request.
- A level-mode secondary line that drops before acknowledge. This must give the secondary spurious vector; a design that clears line 2 along with the secondary line would report the primary spurious vector instead.
- Writes to masked trigger bits. A design that ignores the masks lets a pulsed line vanish.
- A pulse on external line 2. A design that leaves it connected would raise `int_o`.
- Bases with nonzero low bits, and acknowledges with nothing pending. These expose vector arithmetic that carries those bits into the result.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CORE_N = 8;
  localparam int IDX_W  = $clog2(CORE_N);
  localparam int SPUR   = CORE_N - 1;

  typedef logic [CORE_N-1:0] line_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef struct packed {
    logic hit;
    idx_t idx;
  } win_t;

  // lowest-numbered set bit wins; idx defaults to the spurious line
  function automatic win_t first_set(input line_t v);
    win_t w;
    w.hit = 1'b0;
    w.idx = idx_t'(SPUR);
    for (int i = CORE_N - 1; i >= 0; i--) begin
      if (v[i]) begin
        w.hit = 1'b1;
        w.idx = idx_t'(i);
      end
    end
    return w;
  endfunction

  // base with its low index bits cleared, then the line number added in
  function automatic logic [7:0] make_vector(input logic [7:0] base, input idx_t idx);
    logic [7:0] aligned;
    aligned = base & ~8'(CORE_N - 1);
    return aligned | 8'(idx);
  endfunction
endpackage

// File: rtl/irq_core.sv
module irq_core
  import irq_pkg::*;
#(
  parameter line_t TRIG_MASK = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_t req,
  input  line_t trig,
  input  line_t inject,
  input  logic  clr_en,
  input  idx_t  clr_idx,
  output line_t pend_q,
  output line_t pend_d,
  output win_t  win
);
  line_t last_q;
  line_t lvl_mode;
  line_t rise;
  line_t clr_vec;

  assign lvl_mode = trig & TRIG_MASK;
  assign rise     = req & ~last_q;
  assign clr_vec  = clr_en ? (line_t'(1) << clr_idx) : '0;

  for (genvar i = 0; i < CORE_N; i++) begin : g_line
    assign pend_d[i] = lvl_mode[i] ? req[i]
                     : ((pend_q[i] & ~clr_vec[i]) | rise[i] | inject[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      last_q <= '0;
    end else begin
      pend_q <= pend_d;
      last_q <= req;
    end
  end

  assign win = first_set(pend_q);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_pkg::*;
#(
  parameter line_t PRI_TRIG_MASK = 8'hF8,
  parameter line_t SEC_TRIG_MASK = 8'hDE,
  parameter int    CASC_LINE     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*CORE_N-1:0] req_i,
  input  logic [CORE_N-1:0]   trig_pri_i,
  input  logic [CORE_N-1:0]   trig_sec_i,
  input  logic [7:0]          base_pri_i,
  input  logic [7:0]          base_sec_i,
  input  logic                ack_i,
  output logic                int_o,
  output logic                ack_done_o,
  output logic [7:0]          vec_o,
  output logic [IDX_W:0]      irq_num_o
);
  localparam line_t CASC_BIT = line_t'(1) << CASC_LINE;

  line_t p_pend_q, p_pend_d, s_pend_q, s_pend_d;
  win_t  p_win, s_win;

  // named events for the checker
  logic sec_pend_any;
  logic pri_pend_any;
  logic pri_casc_hit;
  logic sec_next_any;

  assign sec_pend_any = |s_pend_q;
  assign pri_pend_any = p_win.hit;
  assign pri_casc_hit = p_win.hit && (p_win.idx == idx_t'(CASC_LINE));
  assign sec_next_any = |s_pend_d;

  irq_core #(.TRIG_MASK(SEC_TRIG_MASK)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_i[2*CORE_N-1:CORE_N]),
    .trig    (trig_sec_i),
    .inject  ('0),
    .clr_en  (ack_i && pri_casc_hit && s_win.hit),
    .clr_idx (s_win.idx),
    .pend_q  (s_pend_q),
    .pend_d  (s_pend_d),
    .win     (s_win)
  );

  irq_core #(.TRIG_MASK(PRI_TRIG_MASK & ~CASC_BIT)) u_pri (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_i[CORE_N-1:0] & ~CASC_BIT),
    .trig    (trig_pri_i),
    .inject  (sec_next_any ? CASC_BIT : '0),
    .clr_en  (ack_i && p_win.hit),
    .clr_idx (p_win.idx),
    .pend_q  (p_pend_q),
    .pend_d  (p_pend_d),
    .win     (p_win)
  );

  logic [7:0]     vec_d;
  logic [IDX_W:0] num_d;

  always_comb begin
    if (pri_casc_hit) begin
      vec_d = make_vector(base_sec_i, s_win.idx);
      num_d = {1'b1, s_win.idx};
    end else begin
      vec_d = make_vector(base_pri_i, p_win.idx);
      num_d = {1'b0, p_win.idx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_done_o <= 1'b0;
      vec_o      <= '0;
      irq_num_o  <= '0;
    end else begin
      ack_done_o <= ack_i;
      if (ack_i) begin
        vec_o     <= vec_d;
        irq_num_o <= num_d;
      end
    end
  end

  assign int_o = |p_pend_q;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       ack_done_o,
  input logic [7:0] vec_o,
  input logic [3:0] irq_num_o,
  input logic [7:0] base_pri_i,
  input logic       sec_pend_any,
  input logic       pri_line2,
  input logic       pri_pend_any,
  input logic       pri_casc_hit
);
  assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ack_done_o);

  assert_done_only_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !ack_done_o);

  assert_cascade_marks_line2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pend_any |-> pri_line2);

  assert_vec_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done_o |-> (vec_o[2:0] == irq_num_o[2:0]));

  assert_secondary_number_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done_o |-> (irq_num_o[3] == $past(pri_casc_hit)));

  assert_primary_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done_o && !$past(pri_pend_any)) |-> (vec_o == {$past(base_pri_i[7:3]), 3'd7}));
endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ack_i        (ack_i),
  .ack_done_o   (ack_done_o),
  .vec_o        (vec_o),
  .irq_num_o    (irq_num_o),
  .base_pri_i   (base_pri_i),
  .sec_pend_any (sec_pend_any),
  .pri_line2    (p_pend_q[2]),
  .pri_pend_any (pri_pend_any),
  .pri_casc_hit (pri_casc_hit)
);

// File: tb/tb_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cascade_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic [7:0]  trig_pri = '0, trig_sec = '0;
  logic [7:0]  base_pri = 8'h20, base_sec = 8'h70;
  logic        ack = 1'b0;
  logic        int_o, ack_done_o;
  logic [7:0]  vec_o;
  logic [3:0]  irq_num_o;

  always #4 clk = ~clk;

  irq_cascade_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .trig_pri_i(trig_pri), .trig_sec_i(trig_sec),
    .base_pri_i(base_pri), .base_sec_i(base_sec), .ack_i(ack), .int_o(int_o),
    .ack_done_o(ack_done_o), .vec_o(vec_o), .irq_num_o(irq_num_o)
  );

  int    n_run = 0, n_fail = 0;
  bit    started = 0, finished = 0;
  string cur_req = "R11";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: behavioural, integer based
  bit [7:0] m_p = '0, m_s = '0, m_pl = '0, m_sl = '0;
  bit       m_done = 0;
  int       m_vec = 0, m_irq = 0;
  string    m_case = "R4";

  function automatic int lowest(input bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin : model
    int pw, sw;
    bit [7:0] lp, ls;
    if (!rst_n) begin
      m_p = '0; m_s = '0; m_pl = '0; m_sl = '0; m_done = 0;
    end else begin
      lp = trig_pri & 8'hF8;
      ls = trig_sec & 8'hDE;
      m_done = ack;
      if (ack) begin
        pw = lowest(m_p);
        if (pw < 0) begin
          m_vec = (base_pri / 8) * 8 + 7; m_irq = 7; m_case = "R8";
        end else if (pw == 2) begin
          m_p[2] = 0;
          sw = lowest(m_s);
          if (sw < 0) begin
            m_vec = (base_sec / 8) * 8 + 7; m_irq = 15; m_case = "R7";
          end else begin
            m_vec = (base_sec / 8) * 8 + sw; m_irq = 8 + sw; m_case = "R6";
            if (!ls[sw]) m_s[sw] = 0;
          end
        end else begin
          m_vec = (base_pri / 8) * 8 + pw; m_irq = pw; m_case = "R4";
          if (!lp[pw]) m_p[pw] = 0;
        end
      end
      for (int k = 0; k < 8; k++) begin
        if (ls[k]) m_s[k] = req[8+k];
        else if (req[8+k] && !m_sl[k]) m_s[k] = 1;
        m_sl[k] = req[8+k];
        if (k != 2) begin
          if (lp[k]) m_p[k] = req[k];
          else if (req[k] && !m_pl[k]) m_p[k] = 1;
          m_pl[k] = req[k];
        end
      end
      if (m_s != 0) m_p[2] = 1;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(int_o == (m_p != 0), cur_req, int_o, m_p != 0);
      chk(ack_done_o == m_done, "R10", ack_done_o, m_done);
      if (m_done) begin
        chk(vec_o == m_vec[7:0], m_case, vec_o, m_vec);
        chk(irq_num_o == m_irq[3:0], m_case, irq_num_o, m_irq);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); req[line] = 1'b1;
    @(negedge clk); req[line] = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    chk(int_o == 0 && ack_done_o == 0, "R11", int_o, 0);

    // R1: edge latch survives the line dropping
    cur_req = "R1";
    pulse(5); cyc(3);
    chk(int_o == 1, "R1", int_o, 1);
    do_ack(); chk(vec_o == 8'h25, "R1", vec_o, 8'h25);
    cyc(1);
    // R8: nothing pending
    do_ack(); chk(vec_o == 8'h27 && irq_num_o == 7, "R8", vec_o, 8'h27);

    // R2: level line stays pending through an acknowledge
    cur_req = "R2";
    trig_pri = 8'h10;
    @(negedge clk); req[4] = 1; cyc(2);
    do_ack(); do_ack();
    chk(vec_o == 8'h24 && int_o == 1, "R2", vec_o, 8'h24);
    req[4] = 0; cyc(2);
    chk(int_o == 0, "R2", int_o, 0);
    trig_pri = 8'h00;

    // R3: masked trigger bits stay edge mode
    cur_req = "R3";
    trig_pri = 8'h07; trig_sec = 8'h21;
    pulse(1); pulse(8); cyc(2);
    chk(int_o == 1, "R3", int_o, 1);
    do_ack(); chk(vec_o == 8'h21, "R3", vec_o, 8'h21);
    do_ack(); chk(irq_num_o == 8, "R3", irq_num_o, 8);
    trig_pri = 8'h00; trig_sec = 8'h00;
    cyc(2);

    // R4: lowest line wins
    cur_req = "R4";
    @(negedge clk); req[3] = 1; req[6] = 1;
    @(negedge clk); req = '0;
    do_ack(); chk(vec_o == 8'h23, "R4", vec_o, 8'h23);
    do_ack(); chk(vec_o == 8'h26, "R4", vec_o, 8'h26);

    // R5: external line 2 has no effect, cascade does
    cur_req = "R5";
    pulse(2); cyc(2);
    chk(int_o == 0, "R5", int_o, 0);
    pulse(10); cyc(1);
    chk(int_o == 1, "R5", int_o, 1);
    // R6: cascaded vector
    do_ack(); chk(vec_o == 8'h72 && irq_num_o == 10, "R6", vec_o, 8'h72);
    cyc(1);

    // R6: two secondary lines, line 2 re-marked after first acknowledge
    cur_req = "R6";
    @(negedge clk); req[9] = 1; req[12] = 1;
    @(negedge clk); req = '0;
    do_ack(); chk(irq_num_o == 9, "R6", irq_num_o, 9);
    do_ack(); chk(irq_num_o == 12, "R6", irq_num_o, 12);
    cyc(1);
    chk(int_o == 0, "R6", int_o, 0);

    // R7: secondary level line drops before acknowledge
    cur_req = "R7";
    trig_sec = 8'h02;
    @(negedge clk); req[9] = 1; cyc(2);
    req[9] = 0; cyc(2);
    chk(int_o == 1, "R7", int_o, 1);
    do_ack(); chk(vec_o == 8'h77 && irq_num_o == 15, "R7", vec_o, 8'h77);
    trig_sec = 8'h00;

    // R9: low base bits ignored
    cur_req = "R9";
    base_pri = 8'h4D; base_sec = 8'hB6;
    do_ack(); chk(vec_o == 8'h4F, "R9", vec_o, 8'h4F);
    pulse(11); cyc(1);
    do_ack(); chk(vec_o == 8'hB3, "R9", vec_o, 8'hB3);
    pulse(6); cyc(1);
    do_ack(); chk(vec_o == 8'h4E, "R9", vec_o, 8'h4E);

    // R11: reset clears pending state
    cur_req = "R11";
    pulse(0); cyc(1);
    started = 0;
    @(negedge clk); rst_n = 0;
    cyc(2); rst_n = 1;
    @(negedge clk); started = 1;
    chk(int_o == 0, "R11", int_o, 0);
    cyc(4);
    finish_run();
  end
endmodule